// File: doc/BRIEF.md
# Packet-Aware Receive Byte Queue

This block buffers the bytes arriving from a serial byte interface before a central router consumes them. Everything runs in one clock domain. Each incoming byte comes with a one-cycle strobe. The byte is staged for one cycle and then written into a power-of-two ring of byte storage that behaves like block RAM. The ring is addressed by wrapping head and tail pointers, and the occupancy is the tail minus the head, modulo the depth.

The router pops bytes one at a time. A read returns its data one cycle after the pop is accepted, because the storage has a registered read port. The queue knows how packets are framed, and every packet has a fixed length chosen by a 2-bit size code. While no packet is in progress, pops are refused until more than two bytes are queued, so the header bytes, destination included, are always present before a packet starts. A position counter follows the bytes of the current packet and returns to idle after the last one.

A congestion flag tells the interface side that the queue is nearly full. It rises when occupancy leaves less than one packet of free room. It falls only after occupancy drops below half the depth. A byte that arrives while the ring is full is discarded, and a sticky overflow flag records the loss.

Top module: `pkt_rx_queue`

## Requirements
- R1: While `rst_n` is low, and for two clock edges after it rises, `occupancy` is 0 and `hdr_ready`, `in_pkt`, `rd_valid`, `rd_last`, `congested` and `overflow` are all 0.
- R2: A byte strobed on `wr_stb` at clock edge t is stored at edge t+1, so `occupancy` first counts it after edge t+1 and not after edge t.
- R3: `occupancy` equals bytes stored minus bytes popped. It changes by at most one per cycle, and the ring holds at most DEPTH-1 bytes.
- R4: Bytes leave in arrival order. An accepted pop at edge t gives `rd_valid`=1 with the byte on `rd_data` after edge t+1.
- R5: A pop while `occupancy` is 0 is ignored: no `rd_valid` follows and `occupancy` is unchanged.
- R6: While `in_pkt` is 0, a pop is accepted only when `occupancy` > 2. `hdr_ready` is 1 exactly when `in_pkt` is 0 and `occupancy` > 2.
- R7: The size code is sampled on the first pop of a packet: code 0 selects PKT_SZ0 (default 64), code 1 PKT_SZ1 (32), code 2 PKT_SZ2 (128) and code 3 PKT_SZ3 (256). `rd_last` marks the last byte of that size, after which `in_pkt` returns to 0. A code change in mid-packet has no effect on that packet.
- R8: If `occupancy` >= DEPTH minus the size selected by `size_sel` at edge t, `congested` is 1 after edge t.
- R9: `congested` clears after an edge where `occupancy` < DEPTH/2 and the set condition is false. Otherwise it holds its value.
- R10: A byte reaching storage while `occupancy` is DEPTH-1 is dropped, and `overflow` is set and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb | input | 1 | One-cycle strobe for an incoming byte |
| wr_data | input | 8 | Incoming byte |
| size_sel | input | 2 | Packet size code |
| pop | input | 1 | Router requests the next byte |
| rd_data | output | 8 | Popped byte, valid with `rd_valid` |
| rd_valid | output | 1 | `rd_data` carries a popped byte |
| rd_last | output | 1 | Popped byte is the last one of its packet |
| hdr_ready | output | 1 | Idle and more than two bytes queued |
| in_pkt | output | 1 | A packet is partly popped |
| occupancy | output | ADDR_W | Bytes held in the ring |
| congested | output | 1 | Nearly-full indication with hysteresis |
| overflow | output | 1 | Sticky flag for a dropped byte |

## Verification
The bench builds the queue with a 5-bit address, which gives a 32-byte ring, and with packet sizes 4, 8, 12 and 16. At that depth a few dozen writes fill the ring, so the full, drop and overflow paths are exercised. Many packet boundaries and size changes occur within one run. The congestion threshold also moves with the size code, from 28 down to 16; at 16 it equals the release point of half the depth. A behavioural model built on a byte queue is compared with every output on every cycle, across directed phases and a long random mix of writes and pops.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef logic [1:0] size_code_t;

  function automatic int unsigned pick_size(input size_code_t code,
                                            input int unsigned s0,
                                            input int unsigned s1,
                                            input int unsigned s2,
                                            input int unsigned s3);
    int unsigned r;
    case (code)
      2'd0:    r = s0;
      2'd1:    r = s1;
      2'd2:    r = s2;
      default: r = s3;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rxq_ram.sv
module rxq_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop_ok,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [ADDR_W-1:0] head,
  output logic [ADDR_W-1:0] occ,
  output logic              overflow
);
  logic              stage_v_q, stage_v_d;
  logic [DATA_W-1:0] stage_d_q;
  logic              stage_d_en;
  logic [ADDR_W-1:0] tail_q, tail_d, head_q, head_d;
  logic              ovf_q, ovf_d;
  logic              full, accept;

  always_comb begin
    occ        = tail_q - head_q;
    full       = &occ;
    accept     = stage_v_q & ~full;
    stage_v_d  = wr_stb;
    stage_d_en = wr_stb;
    tail_d     = accept ? tail_q + 1'b1 : tail_q;
    head_d     = pop_ok ? head_q + 1'b1 : head_q;
    ovf_d      = ovf_q | (stage_v_q & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_v_q <= 1'b0;
      stage_d_q <= '0;
      tail_q    <= '0;
      head_q    <= '0;
      ovf_q     <= 1'b0;
    end else begin
      stage_v_q <= stage_v_d;
      if (stage_d_en) stage_d_q <= wr_data;
      tail_q    <= tail_d;
      head_q    <= head_d;
      ovf_q     <= ovf_d;
    end
  end

  assign ram_we    = accept;
  assign ram_waddr = tail_q;
  assign ram_wdata = stage_d_q;
  assign head      = head_q;
  assign overflow  = ovf_q;
endmodule

// File: rtl/rxq_pkt.sv
module rxq_pkt
  import rxq_pkg::*;
#(
  parameter int          ADDR_W  = 10,
  parameter int          CNT_W   = 11,
  parameter int unsigned PKT_SZ0 = 64,
  parameter int unsigned PKT_SZ1 = 32,
  parameter int unsigned PKT_SZ2 = 128,
  parameter int unsigned PKT_SZ3 = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic [ADDR_W-1:0] occ,
  input  size_code_t        size_sel,
  output logic              pop_ok,
  output logic              hdr_ready,
  output logic              in_pkt,
  output logic              rd_valid,
  output logic              rd_last
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cur_q, cur_d, sel_sz, eff_sz;
  logic             is_last, rdv_d, last_d, rdv_q, last_q;

  always_comb begin
    sel_sz    = CNT_W'(pick_size(size_sel, PKT_SZ0, PKT_SZ1, PKT_SZ2, PKT_SZ3));
    in_pkt    = |cnt_q;
    hdr_ready = ~in_pkt & (occ > ADDR_W'(2));
    pop_ok    = pop & (|occ) & (in_pkt | (occ > ADDR_W'(2)));
    eff_sz    = in_pkt ? cur_q : sel_sz;
    is_last   = (cnt_q == eff_sz - CNT_W'(1));
    cnt_d     = cnt_q;
    cur_d     = cur_q;
    if (pop_ok) begin
      cnt_d = is_last ? '0 : cnt_q + CNT_W'(1);
      if (!in_pkt) cur_d = sel_sz;
    end
    rdv_d  = pop_ok;
    last_d = pop_ok & is_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cur_q  <= '0;
      rdv_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cur_q  <= cur_d;
      rdv_q  <= rdv_d;
      last_q <= last_d;
    end
  end

  assign rd_valid = rdv_q;
  assign rd_last  = last_q;
endmodule

// File: rtl/rxq_cong.sv
module rxq_cong
  import rxq_pkg::*;
#(
  parameter int          ADDR_W  = 10,
  parameter int unsigned PKT_SZ0 = 64,
  parameter int unsigned PKT_SZ1 = 32,
  parameter int unsigned PKT_SZ2 = 128,
  parameter int unsigned PKT_SZ3 = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] occ,
  input  size_code_t        size_sel,
  output logic              congested
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W:0] thr;
  logic            set_c, clr_c, cong_q, cong_d;

  always_comb begin
    thr    = (ADDR_W+1)'(DEPTH)
           - (ADDR_W+1)'(pick_size(size_sel, PKT_SZ0, PKT_SZ1, PKT_SZ2, PKT_SZ3));
    set_c  = ({1'b0, occ} >= thr);
    clr_c  = (occ < ADDR_W'(DEPTH / 2));
    cong_d = set_c ? 1'b1 : (clr_c ? 1'b0 : cong_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cong_q <= 1'b0;
    else        cong_q <= cong_d;
  end

  assign congested = cong_q;
endmodule

// File: rtl/pkt_rx_queue.sv
module pkt_rx_queue
  import rxq_pkg::*;
#(
  parameter int          ADDR_W  = 10,
  parameter int          DATA_W  = 8,
  parameter int unsigned PKT_SZ0 = 64,
  parameter int unsigned PKT_SZ1 = 32,
  parameter int unsigned PKT_SZ2 = 128,
  parameter int unsigned PKT_SZ3 = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        size_sel,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_last,
  output logic              hdr_ready,
  output logic              in_pkt,
  output logic [ADDR_W-1:0] occupancy,
  output logic              congested,
  output logic              overflow
);
  localparam int CNT_W = ADDR_W + 1;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              pop_ok, ram_we;
  logic [ADDR_W-1:0] ram_waddr, head, occ;
  logic [DATA_W-1:0] ram_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rxq_ptrs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptrs (
    .clk(clk), .rst_n(rst_int_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .pop_ok(pop_ok), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .head(head), .occ(occ), .overflow(overflow)
  );

  rxq_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(head), .rdata(rd_data)
  );

  rxq_pkt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PKT_SZ0(PKT_SZ0),
            .PKT_SZ1(PKT_SZ1), .PKT_SZ2(PKT_SZ2), .PKT_SZ3(PKT_SZ3)) u_pkt (
    .clk(clk), .rst_n(rst_int_n), .pop(pop), .occ(occ), .size_sel(size_sel),
    .pop_ok(pop_ok), .hdr_ready(hdr_ready), .in_pkt(in_pkt),
    .rd_valid(rd_valid), .rd_last(rd_last)
  );

  rxq_cong #(.ADDR_W(ADDR_W), .PKT_SZ0(PKT_SZ0), .PKT_SZ1(PKT_SZ1),
             .PKT_SZ2(PKT_SZ2), .PKT_SZ3(PKT_SZ3)) u_cong (
    .clk(clk), .rst_n(rst_int_n), .occ(occ), .size_sel(size_sel),
    .congested(congested)
  );

  assign occupancy = occ;
endmodule

// File: rtl/pkt_rx_queue_chk.sv
module pkt_rx_queue_chk
  import rxq_pkg::*;
#(
  parameter int          ADDR_W  = 10,
  parameter int unsigned PKT_SZ0 = 64,
  parameter int unsigned PKT_SZ1 = 32,
  parameter int unsigned PKT_SZ2 = 128,
  parameter int unsigned PKT_SZ3 = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        size_sel,
  input logic              rd_valid,
  input logic              rd_last,
  input logic              in_pkt,
  input logic [ADDR_W-1:0] occupancy,
  input logic              congested,
  input logic              overflow
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W:0] thr_c;
  assign thr_c = (ADDR_W+1)'(DEPTH)
               - (ADDR_W+1)'(pick_size(size_sel, PKT_SZ0, PKT_SZ1, PKT_SZ2, PKT_SZ3));

  AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == $past(occupancy)) || (occupancy == $past(occupancy) + 1'b1)
    || (occupancy == $past(occupancy) - 1'b1)); // R3
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(occupancy) != '0)); // R5
  AST_HDR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !$past(in_pkt)) |-> ($past(occupancy) > ADDR_W'(2))); // R6
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid); // R7
  AST_CONG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, occupancy} >= thr_c) |=> congested); // R8
  AST_CONG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((occupancy < ADDR_W'(DEPTH / 2)) && ({1'b0, occupancy} < thr_c)) |=> !congested); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R10
endmodule

bind pkt_rx_queue pkt_rx_queue_chk #(
  .ADDR_W(ADDR_W), .PKT_SZ0(PKT_SZ0), .PKT_SZ1(PKT_SZ1),
  .PKT_SZ2(PKT_SZ2), .PKT_SZ3(PKT_SZ3)
) u_chk (
  .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .rd_valid(rd_valid),
  .rd_last(rd_last), .in_pkt(in_pkt), .occupancy(occupancy),
  .congested(congested), .overflow(overflow)
);

// File: tb/pkt_rx_queue_tb.sv
module pkt_rx_queue_tb;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;
  localparam int S0 = 4, S1 = 8, S2 = 12, S3 = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] size_sel = '0;
  logic pop = 1'b0;
  logic [7:0] rd_data;
  logic rd_valid, rd_last, hdr_ready, in_pkt, congested, overflow;
  logic [AW-1:0] occupancy;

  int vectors = 0, miscompares = 0;
  bit cmp_en = 0;

  always #2 clk = ~clk;

  pkt_rx_queue #(.ADDR_W(AW), .DATA_W(8), .PKT_SZ0(S0), .PKT_SZ1(S1),
                 .PKT_SZ2(S2), .PKT_SZ3(S3)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .size_sel(size_sel), .pop(pop), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_last(rd_last), .hdr_ready(hdr_ready), .in_pkt(in_pkt),
    .occupancy(occupancy), .congested(congested), .overflow(overflow)
  );

  function automatic int msz(input int c);
    case (c)
      0: return S0;
      1: return S1;
      2: return S2;
      default: return S3;
    endcase
  endfunction

  // behavioural model
  logic [7:0] q[$];
  int  m_cnt, m_cur;
  bit  m_rdv, m_last, m_cong, m_ovf, m_pv;
  logic [7:0] m_pd, m_rdd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_cnt = 0; m_cur = 0; m_rdv = 0; m_last = 0;
      m_cong = 0; m_ovf = 0; m_pv = 0; m_pd = '0;
    end else begin
      int occ, eff;
      bit ok, lst;
      occ = q.size();
      ok  = pop && occ != 0 && (m_cnt != 0 || occ > 2);
      lst = 0;
      if (ok) begin
        m_rdd = q.pop_front();
        eff = (m_cnt == 0) ? msz(size_sel) : m_cur;
        if (m_cnt == 0) m_cur = eff;
        lst = (m_cnt == eff - 1);
        m_cnt = lst ? 0 : m_cnt + 1;
      end
      if (m_pv) begin
        if (occ == DEPTH - 1) m_ovf = 1;
        else q.push_back(m_pd);
      end
      m_rdv  = ok;
      m_last = ok && lst;
      if (occ >= DEPTH - msz(size_sel)) m_cong = 1;
      else if (occ < DEPTH / 2) m_cong = 0;
      m_pv = wr_stb;
      m_pd = wr_data;
    end
  end

  task automatic expect_eq(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      expect_eq("R3 occupancy", int'(occupancy), q.size());
      expect_eq("R6 hdr_ready", int'(hdr_ready), int'(m_cnt == 0 && q.size() > 2));
      expect_eq("R7 in_pkt", int'(in_pkt), int'(m_cnt != 0));
      expect_eq("R4 rd_valid", int'(rd_valid), int'(m_rdv));
      if (m_rdv) expect_eq("R4 rd_data", int'(rd_data), int'(m_rdd));
      expect_eq("R7 rd_last", int'(rd_last), int'(m_last));
      expect_eq("R8 R9 congested", int'(congested), int'(m_cong));
      expect_eq("R10 overflow", int'(overflow), int'(m_ovf));
    end
  end

  task automatic drive(input bit ws, input logic [7:0] wd, input bit p, input int ss);
    wr_stb = ws; wr_data = wd; pop = p; size_sel = 2'(ss);
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic check_reset_state();
    expect_eq("R1 occupancy", int'(occupancy), 0);
    expect_eq("R1 flags", int'({hdr_ready, in_pkt, rd_valid, rd_last, congested, overflow}), 0);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    cmp_en = 1;
    repeat (3) tick();
    check_reset_state();
    rst_n = 1'b1;
    tick(); tick();
    check_reset_state();   // R1: synchronous release holds reset two edges
    repeat (2) tick();

    // R5: pop on an empty queue
    drive(0, 8'h00, 1, 0); tick(); tick();
    expect_eq("R5 rd_valid", int'(rd_valid), 0);
    expect_eq("R5 occupancy", int'(occupancy), 0);

    // R2: write latency, R6: header gate
    drive(1, 8'h11, 0, 0); tick();
    expect_eq("R2 occupancy", int'(occupancy), 0);
    drive(1, 8'h22, 0, 0); tick();
    expect_eq("R2 occupancy", int'(occupancy), 1);
    drive(1, 8'h33, 1, 0); tick();
    expect_eq("R6 occupancy", int'(occupancy), 2);
    drive(0, 8'h00, 1, 0); tick();
    expect_eq("R6 rd_valid", int'(rd_valid), 0);
    expect_eq("R6 hdr_ready", int'(hdr_ready), 1);
    tick();
    expect_eq("R4 rd_valid", int'(rd_valid), 1);
    expect_eq("R4 rd_data", int'(rd_data), 8'h11);

    // fill to overflow: R8, R10
    for (int i = 0; i < 40; i++) begin
      drive(1, 8'(8'h40 + i), 0, 3); tick();
    end
    drive(0, 8'h00, 0, 3); tick(); tick();
    expect_eq("R10 overflow", int'(overflow), 1);
    expect_eq("R3 full", int'(occupancy), DEPTH - 1);
    expect_eq("R8 congested", int'(congested), 1);

    // drain with a changing size code: R7, R9
    for (int i = 0; i < 70; i++) begin
      drive(0, 8'h00, 1, i / 5 % 4); tick();
    end
    drive(0, 8'h00, 0, 0); tick();
    expect_eq("R9 congested", int'(congested), 0);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      int mode = (i / 500) % 3;
      int wp = (mode == 0) ? 70 : (mode == 1) ? 40 : 55;
      drive(($urandom % 100) < wp, 8'($urandom), ($urandom % 100) < 50,
            ((i % 37) == 0) ? int'($urandom % 4) : int'(size_sel));
      tick();
    end

    // reset mid-run: R1
    drive(0, 8'h00, 0, 0);
    rst_n = 1'b0;
    tick();
    check_reset_state();
    rst_n = 1'b1;
    repeat (3) tick();
    check_reset_state();
    finish_run();
  end
endmodule